// File: doc/BRIEF.md
# Vector Micro-op Issue Selector

The block chooses, once per cycle, which micro-ops in an eight-entry ready window are sent to four vector execution units and to one store lane. Each candidate carries a valid bit, an operation class and three bypass flags, one per source operand. Two constraints limit the choice. The first is unit capability: only units 0 and 1 can multiply. The second is a shared pool of ten register-file read ports. An operand that arrives over a bypass path takes no port, so a group of micro-ops that would not fit on raw operand count can still issue together.

Candidates are examined oldest first, with index 0 the oldest. Each candidate issues only when a suitable unit or lane is still free and its port cost fits within the ports left over. A candidate that cannot issue is skipped, and younger candidates can still issue in the same cycle. Multiply-class work goes to the multiply units. Simple work goes first to the units that cannot multiply, so the multiply units stay free. The whole decision is registered, and the grants appear one clock after the window is presented.

Top module: `simd_issue_sel`

## Requirements
- R1: Outputs are registered. A window presented before a rising clock edge is reflected after that edge. While rst_ni is low, every grant, index and issued output is zero.
- R2: Class codes are 0 FADD (2 sources), 1 FMUL (2), 2 FMA (3), 3 simple integer (2) and 4 STORE (1). A valid candidate with code 5, 6 or 7 never issues.
- R3: FMUL and FMA issue only on units 0 and 1, and the lower free unit is taken first. When both are busy, the candidate is skipped.
- R4: FADD and integer ops take the lowest free unit among units 2 and 3. Only when both of those are busy do they fall back to the lowest free unit among units 0 and 1.
- R5: A candidate's port cost is its source count minus the number of set bypass flags among its used source slots. Bit k of the candidate's 3-bit flag field stands for source k. Flags on slots beyond the source count are ignored.
- R6: The summed port cost of everything issued in one cycle never exceeds 10. A candidate whose cost would exceed the remaining ports is skipped.
- R7: Candidates are considered in index order, with index 0 first. A skipped candidate does not block any younger one.
- R8: Each unit and the store lane take at most one candidate per cycle. unit_idx_o and store_idx_o name the granted candidate. issued_o is set exactly for the granted candidates.
- R9: Only STORE uses the store lane. A candidate with valid low never issues.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| valid_i | input | 8 | Candidate present, one bit per window entry |
| cls_i | input | 24 | 3-bit class per candidate, entry i at bits [3i+2:3i] |
| byp_i | input | 24 | 3-bit bypass flags per candidate, entry i at bits [3i+2:3i] |
| unit_gnt_o | output | 4 | Execution unit u received a micro-op |
| unit_idx_o | output | 12 | 3-bit candidate index per unit, unit u at bits [3u+2:3u] |
| store_gnt_o | output | 1 | Store lane received a micro-op |
| store_idx_o | output | 3 | Candidate index sent to the store lane |
| issued_o | output | 8 | Per-candidate issued flag |

## Verification
The hardest case to reach from the ports is the one where the read-port budget, not unit availability, blocks an issue. With four units and two-source and three-source ops alone, ten ports always suffice. The budget only binds when a store competes with two FMAs and two adds. The bench therefore builds that exact window with the store placed both oldest and youngest. It then repeats the window with a bypass flag set on a used slot and on an unused slot, to show that only the used one frees a port. Random windows are compared against a behavioural reference model on every clock.

// File: rtl/simd_issue_pkg.sv
package simd_issue_pkg;

  typedef enum logic [2:0] {
    CLS_FADD  = 3'd0,
    CLS_FMUL  = 3'd1,
    CLS_FMA   = 3'd2,
    CLS_INT   = 3'd3,
    CLS_STORE = 3'd4
  } op_cls_e;

  localparam int CLS_W = 3;

  function automatic logic [1:0] src_count(logic [2:0] c);
    case (c)
      CLS_FADD, CLS_FMUL, CLS_INT: src_count = 2'd2;
      CLS_FMA:                     src_count = 2'd3;
      CLS_STORE:                   src_count = 2'd1;
      default:                     src_count = 2'd0;
    endcase
  endfunction

  function automatic logic [2:0] slot_mask(logic [1:0] n);
    case (n)
      2'd0:    slot_mask = 3'b000;
      2'd1:    slot_mask = 3'b001;
      2'd2:    slot_mask = 3'b011;
      default: slot_mask = 3'b111;
    endcase
  endfunction

  function automatic logic is_mul(logic [2:0] c);
    is_mul = (c == CLS_FMUL) || (c == CLS_FMA);
  endfunction

endpackage

// File: rtl/simd_port_need.sv
module simd_port_need
  import simd_issue_pkg::*;
(
  input  logic [2:0] cls_i,
  input  logic [2:0] byp_i,
  output logic [1:0] need_o,
  output logic       legal_o
);

  logic [1:0] cnt;
  logic [2:0] used_byp;

  assign cnt      = src_count(cls_i);
  assign used_byp = byp_i & slot_mask(cnt);
  assign need_o   = cnt - 2'($countones(used_byp));
  assign legal_o  = (cls_i <= CLS_STORE);

endmodule

// File: rtl/simd_slot_pick.sv
module simd_slot_pick
  import simd_issue_pkg::*;
#(
  parameter int NUM_UNIT     = 4,
  parameter int NUM_MUL_UNIT = 2,
  parameter int RD_PORTS     = 10,
  parameter int PORT_W       = 4
) (
  input  logic                valid_i,
  input  logic [2:0]          cls_i,
  input  logic [1:0]          need_i,
  input  logic                legal_i,
  input  logic [NUM_UNIT-1:0] unit_free_i,
  input  logic                store_free_i,
  input  logic [PORT_W-1:0]   ports_i,
  output logic [NUM_UNIT-1:0] unit_free_o,
  output logic                store_free_o,
  output logic [PORT_W-1:0]   ports_o,
  output logic [NUM_UNIT-1:0] unit_oh_o,
  output logic                store_o
);

  localparam logic [NUM_UNIT-1:0] MUL_MASK = {NUM_UNIT{1'b1}} >> (NUM_UNIT - NUM_MUL_UNIT);
  localparam logic [NUM_UNIT-1:0] ONE      = {{(NUM_UNIT-1){1'b0}}, 1'b1};

  logic [NUM_UNIT-1:0] mul_free, plain_free, cand_oh;
  logic [PORT_W-1:0]   sum;
  logic                want_mul, want_store, fits, slot_ok, take;

  always_comb begin
    mul_free   = unit_free_i & MUL_MASK;
    plain_free = unit_free_i & ~MUL_MASK;
    want_mul   = is_mul(cls_i);
    want_store = (cls_i == CLS_STORE);
    // steer: multiply work to capable units, simple work away from them
    if (want_mul)         cand_oh = mul_free & (~mul_free + ONE);
    else if (want_store)  cand_oh = '0;
    else if (|plain_free) cand_oh = plain_free & (~plain_free + ONE);
    else                  cand_oh = mul_free & (~mul_free + ONE);
    sum     = ports_i + PORT_W'(need_i);
    fits    = (sum <= PORT_W'(RD_PORTS));
    slot_ok = want_store ? store_free_i : (|cand_oh);
    take    = valid_i && legal_i && slot_ok && fits;
    unit_oh_o    = (take && !want_store) ? cand_oh : '0;
    store_o      = take && want_store;
    unit_free_o  = unit_free_i & ~unit_oh_o;
    store_free_o = store_free_i & ~store_o;
    ports_o      = take ? sum : ports_i;
  end

endmodule

// File: rtl/simd_issue_sel.sv
module simd_issue_sel
  import simd_issue_pkg::*;
#(
  parameter int NUM_CAND     = 8,
  parameter int NUM_UNIT     = 4,
  parameter int NUM_MUL_UNIT = 2,
  parameter int RD_PORTS     = 10,
  localparam int IDX_W       = $clog2(NUM_CAND),
  localparam int PORT_W      = $clog2(RD_PORTS + 4) + 1
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [NUM_CAND-1:0]       valid_i,
  input  logic [NUM_CAND*CLS_W-1:0] cls_i,
  input  logic [NUM_CAND*3-1:0]     byp_i,
  output logic [NUM_UNIT-1:0]       unit_gnt_o,
  output logic [NUM_UNIT*IDX_W-1:0] unit_idx_o,
  output logic                      store_gnt_o,
  output logic [IDX_W-1:0]          store_idx_o,
  output logic [NUM_CAND-1:0]       issued_o
);

  logic [NUM_UNIT-1:0] free_c  [NUM_CAND+1];
  logic                sfree_c [NUM_CAND+1];
  logic [PORT_W-1:0]   ports_c [NUM_CAND+1];
  logic [NUM_UNIT-1:0] unit_oh [NUM_CAND];
  logic [NUM_CAND-1:0] st_oh;

  assign free_c[0]  = '1;
  assign sfree_c[0] = 1'b1;
  assign ports_c[0] = '0;

  for (genvar i = 0; i < NUM_CAND; i++) begin : g_cand
    logic [1:0] need;
    logic       legal;

    simd_port_need u_need (
      .cls_i  (cls_i[i*CLS_W +: CLS_W]),
      .byp_i  (byp_i[i*3 +: 3]),
      .need_o (need),
      .legal_o(legal)
    );

    simd_slot_pick #(
      .NUM_UNIT    (NUM_UNIT),
      .NUM_MUL_UNIT(NUM_MUL_UNIT),
      .RD_PORTS    (RD_PORTS),
      .PORT_W      (PORT_W)
    ) u_pick (
      .valid_i     (valid_i[i]),
      .cls_i       (cls_i[i*CLS_W +: CLS_W]),
      .need_i      (need),
      .legal_i     (legal),
      .unit_free_i (free_c[i]),
      .store_free_i(sfree_c[i]),
      .ports_i     (ports_c[i]),
      .unit_free_o (free_c[i+1]),
      .store_free_o(sfree_c[i+1]),
      .ports_o     (ports_c[i+1]),
      .unit_oh_o   (unit_oh[i]),
      .store_o     (st_oh[i])
    );
  end

  logic [NUM_UNIT-1:0]       gnt_d;
  logic [NUM_UNIT*IDX_W-1:0] idx_d;
  logic                      st_d;
  logic [IDX_W-1:0]          sidx_d;
  logic [NUM_CAND-1:0]       iss_d;

  always_comb begin
    gnt_d  = '0;
    idx_d  = '0;
    st_d   = 1'b0;
    sidx_d = '0;
    iss_d  = '0;
    for (int i = 0; i < NUM_CAND; i++) begin
      iss_d[i] = (|unit_oh[i]) | st_oh[i];
      for (int u = 0; u < NUM_UNIT; u++) begin
        if (unit_oh[i][u]) begin
          gnt_d[u]                = 1'b1;
          idx_d[u*IDX_W +: IDX_W] = IDX_W'(i);
        end
      end
      if (st_oh[i]) begin
        st_d   = 1'b1;
        sidx_d = IDX_W'(i);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      unit_gnt_o  <= '0;
      unit_idx_o  <= '0;
      store_gnt_o <= 1'b0;
      store_idx_o <= '0;
      issued_o    <= '0;
    end else begin
      unit_gnt_o  <= gnt_d;
      unit_idx_o  <= idx_d;
      store_gnt_o <= st_d;
      store_idx_o <= sidx_d;
      issued_o    <= iss_d;
    end
  end

  // ---- checks ----
  logic [NUM_CAND*CLS_W-1:0] cls_q;
  logic [NUM_CAND*3-1:0]     byp_q;
  logic [NUM_CAND-1:0]       valid_q;
  int                        used_ports;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cls_q   <= '0;
      byp_q   <= '0;
      valid_q <= '0;
    end else begin
      cls_q   <= cls_i;
      byp_q   <= byp_i;
      valid_q <= valid_i;
    end
  end

  always_comb begin
    used_ports = 0;
    for (int i = 0; i < NUM_CAND; i++) begin
      if (issued_o[i]) begin
        used_ports += int'(src_count(cls_q[i*CLS_W +: CLS_W]))
                    - $countones(byp_q[i*3 +: 3] & slot_mask(src_count(cls_q[i*CLS_W +: CLS_W])));
      end
    end
  end

  assert_port_budget_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    used_ports <= RD_PORTS);

  assert_one_per_lane_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(issued_o) == $countones(unit_gnt_o) + int'(store_gnt_o));

  assert_valid_only_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (issued_o & ~valid_q) == '0);

  assert_store_lane_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    store_gnt_o |-> (cls_q[store_idx_o*CLS_W +: CLS_W] == CLS_STORE));

  for (genvar u = NUM_MUL_UNIT; u < NUM_UNIT; u++) begin : g_chk_unit
    assert_no_mul_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      unit_gnt_o[u] |-> !is_mul(cls_q[unit_idx_o[u*IDX_W +: IDX_W]*CLS_W +: CLS_W]));
  end

endmodule

// File: tb/simd_issue_sel_tb_top.sv
`timescale 1ns/1ps
module simd_issue_sel_tb_top;

  localparam int NC = 8;
  localparam int NU = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NC-1:0] valid;
  logic [NC*3-1:0] cls, byp;
  logic [NU-1:0] unit_gnt;
  logic [NU*3-1:0] unit_idx;
  logic          store_gnt;
  logic [2:0]    store_idx;
  logic [NC-1:0] issued;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  int v_a [NC];
  int c_a [NC];
  int b_a [NC];
  int e_gnt [NU];
  int e_idx [NU];
  int e_sg, e_sidx;
  int e_iss [NC];

  always #10 clk = ~clk;

  simd_issue_sel dut_i (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .cls_i(cls), .byp_i(byp),
    .unit_gnt_o(unit_gnt), .unit_idx_o(unit_idx), .store_gnt_o(store_gnt),
    .store_idx_o(store_idx), .issued_o(issued)
  );

  task automatic model();
    int left = 10;
    int busy [NU];
    int sbusy = 0;
    for (int u = 0; u < NU; u++) begin busy[u] = 0; e_gnt[u] = 0; e_idx[u] = 0; end
    e_sg = 0; e_sidx = 0;
    for (int c = 0; c < NC; c++) begin
      int k = c_a[c];
      int src, cost, pick;
      e_iss[c] = 0;
      if (v_a[c] == 0 || k > 4) continue;
      src = (k == 2) ? 3 : (k == 4) ? 1 : 2;
      cost = src;
      for (int s = 0; s < src; s++) if ((b_a[c] >> s) & 1) cost--;
      if (cost > left) continue;
      pick = -1;
      if (k == 4) begin
        if (sbusy == 0) begin sbusy = 1; e_sg = 1; e_sidx = c; e_iss[c] = 1; left -= cost; end
        continue;
      end
      if (k == 1 || k == 2) begin
        if (!busy[0]) pick = 0; else if (!busy[1]) pick = 1;
      end else begin
        if (!busy[2]) pick = 2; else if (!busy[3]) pick = 3;
        else if (!busy[0]) pick = 0; else if (!busy[1]) pick = 1;
      end
      if (pick < 0) continue;
      busy[pick] = 1; e_gnt[pick] = 1; e_idx[pick] = c; e_iss[c] = 1; left -= cost;
    end
  endtask

  task automatic one(string tag, int act, int exp, string what);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic compare(string tag);
    for (int c = 0; c < NC; c++) one(tag, int'(issued[c]), e_iss[c], $sformatf("issued[%0d]", c));
    for (int u = 0; u < NU; u++) begin
      one(tag, int'(unit_gnt[u]), e_gnt[u], $sformatf("unit_gnt[%0d]", u));
      if (e_gnt[u] != 0) one(tag, int'(unit_idx[u*3 +: 3]), e_idx[u], $sformatf("unit_idx[%0d]", u));
    end
    one(tag, int'(store_gnt), e_sg, "store_gnt");
    if (e_sg != 0) one(tag, int'(store_idx), e_sidx, "store_idx");
  endtask

  // drive at negedge, registered result visible at next negedge
  task automatic apply(string tag);
    for (int c = 0; c < NC; c++) begin
      valid[c] = v_a[c][0];
      cls[c*3 +: 3] = c_a[c][2:0];
      byp[c*3 +: 3] = b_a[c][2:0];
    end
    model();
    @(negedge clk);
    compare(tag);
  endtask

  task automatic clear();
    for (int c = 0; c < NC; c++) begin v_a[c] = 0; c_a[c] = 0; b_a[c] = 0; end
  endtask

  task automatic set(int c, int k, int b);
    v_a[c] = 1; c_a[c] = k; b_a[c] = b;
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    valid = '1; cls = '0; byp = '0;
    repeat (3) @(negedge clk);
    // R1: reset holds outputs low despite a full window
    one("R1", int'(issued), 0, "issued in reset");
    one("R1", int'(unit_gnt), 0, "unit_gnt in reset");
    one("R1", int'(store_gnt), 0, "store_gnt in reset");
    rst_n = 1'b1;

    // R6: two FMA + two FADD use exactly ten ports
    clear(); set(0, 2, 0); set(1, 2, 0); set(2, 0, 0); set(3, 0, 0); apply("R6");
    // R1: empty window clears grants next cycle
    clear(); apply("R1");
    // R3 / R7: third FMA skipped, younger add still issues
    clear(); set(0, 2, 0); set(1, 1, 0); set(2, 2, 0); set(3, 0, 0); apply("R3");
    // R4: integer ops fill units 2,3 then fall back to 0
    clear(); set(0, 3, 0); apply("R4");
    clear(); set(0, 3, 0); set(1, 3, 0); set(2, 0, 0); set(3, 2, 0); apply("R4");
    // R6: youngest store blocked by budget
    clear(); set(0, 2, 0); set(1, 2, 0); set(2, 0, 0); set(3, 0, 0); set(4, 4, 0); apply("R6");
    // R6 / R7: oldest store issues, last add blocked
    clear(); set(0, 4, 0); set(1, 2, 0); set(2, 2, 0); set(3, 0, 0); set(4, 0, 0); apply("R7");
    // R5: bypass on a used slot frees one port for the store
    clear(); set(0, 2, 0); set(1, 2, 0); set(2, 0, 1); set(3, 0, 0); set(4, 4, 0); apply("R5");
    // R5: flag on unused slot 2 of an add saves nothing
    clear(); set(0, 2, 0); set(1, 2, 0); set(2, 0, 4); set(3, 0, 0); set(4, 4, 0); apply("R5");
    // R9: second store has no lane; invalid entries never issue
    clear(); set(0, 4, 0); set(1, 4, 0); c_a[2] = 2; c_a[3] = 0; apply("R9");
    // R2: reserved codes never issue
    clear(); set(0, 5, 0); set(1, 6, 0); set(2, 7, 0); set(3, 3, 0); apply("R2");

    // R8: random windows against the reference model
    for (int n = 0; n < 3000; n++) begin
      for (int c = 0; c < NC; c++) begin
        int r = int'($urandom_range(0, 15));
        v_a[c] = ($urandom_range(0, 3) != 0) ? 1 : 0;
        c_a[c] = (r < 8) ? (r % 5) : (r < 14 ? (r % 3) + 1 : int'($urandom_range(5, 7)));
        b_a[c] = int'($urandom_range(0, 7));
      end
      apply("R8");
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule